// File: doc/BRIEF.md
# Dual-Domain Reset Controller

This block merges several reset requests into two active-high reset outputs. One output resets the memory-controller domain, which keeps the DRAM refreshed. The other resets everything else on the chip, including the devices driven from the external reset line. There are four requests: an active-low external reset pin, a software reset bit, a watchdog expiry pulse and an active-low memory-reset-enable pin. The enable pin decides whether each request also reaches the memory domain. Leaving the enable pin released keeps DRAM refresh running, at its programmed rate and timing, while the rest of the system restarts.

Both pins pass through a synchronizer. The synchronized levels are sorted into four reset kinds: master, normal, watchdog and software. Each output is stretched so that a short request still produces a clean reset of fixed minimum length. A small write port lets software request a reset and clear the cause register. The cause register records, as a one-hot code, which kind of reset happened last. Only a master reset clears it.

Top module: `rstc_top`

## Requirements
- R1: Each pin passes through a two-flop synchronizer. A pin level sampled at clock edge n affects the reset outputs after edge n+2.
- R2: Master reset occurs when `ext_rst_n` and `mem_rst_en_n` are both low. It asserts `sys_rst_o` and `mem_rst_o` together.
- R3: Normal reset occurs when `ext_rst_n` is low while `mem_rst_en_n` is high. It asserts `sys_rst_o` and leaves `mem_rst_o` low.
- R4: A one-cycle high on `wdog_expire` asserts `sys_rst_o` after the next edge. It asserts `mem_rst_o` as well only while the synchronized enable pin is low.
- R5: A write with `reg_addr`=0 and `reg_wdata[0]`=1 sets `soft_pending_o` on that edge. `sys_rst_o` follows on the next edge. `mem_rst_o` follows as well only while the synchronized enable pin is low.
- R6: After the last cycle in which a domain's request is present, its output stays high for HOLD_CYCLES+1 further edges (default 16, giving 17 edges), then drops.
- R7: `soft_pending_o` clears on the edge after `sys_rst_o` falls, and the reset does not fire again. Writes of either kind are ignored while `sys_rst_o` is high.
- R8: `cause_o` is one-hot. Bit 0 means master, bit 1 normal, bit 2 watchdog and bit 3 software. Each new reset replaces the old value, and a master reset leaves exactly 4'b0001.
- R9: When several reset kinds arrive in the same cycle, the cause records the highest-priority one. The order, highest first, is master, normal, watchdog, software.
- R10: A write with `reg_addr`=1 clears each `cause_o` bit whose matching `reg_wdata` bit is 1, on the write edge. Bits written as 0 stay unchanged.
- R11: `mem_rst_en_n` low on its own, with no other request, asserts neither output and leaves `cause_o` unchanged. `mem_rst_o` is never high while `sys_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mem_rst_en_n | input | 1 | Memory-domain reset enable pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog expiry pulse, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control (bit 0 requests soft reset), 1: cause clear |
| reg_wdata | input | 4 | Write data |
| sys_rst_o | output | 1 | Reset for the general chip domain and external devices, active high |
| mem_rst_o | output | 1 | Reset for the memory-controller domain, active high |
| soft_pending_o | output | 1 | Software reset bit, self-clearing |
| cause_o | output | 4 | One-hot last-reset cause |

## Verification
A pin change takes three edges to reach an output: two synchronizer flops and the output register. The bench drives pins on falling edges and samples exactly two and three edges later, so the latency is pinned from both sides. The watchdog pulse and a register write reach their registers on the first edge. The software reset then fires one edge after its write. Each release is checked on the last edge the output must still be high and again on the first edge it must be low. The self-clear of the software bit is checked one edge after that.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned CAUSE_W = 4;

  typedef enum int unsigned {
    SRC_MASTER = 0,
    SRC_NORMAL = 1,
    SRC_WDOG   = 2,
    SRC_SOFT   = 3
  } src_e;

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_CAUSE = 1'b1;

  function automatic cause_t cause_bit(src_e s);
    cause_t c;
    c = '0;
    c[s] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic srst,
  input  logic req_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam int unsigned QW = CW + 1;

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt   <= CW'(HOLD);
      rst_q <= 1'b1;
    end else begin
      if (req_i)         cnt <= CW'(HOLD);
      else if (cnt != 0) cnt <= cnt - 1'b1;
      rst_q <= req_i || (cnt != 0);
    end
  end

  assign rst_o = rst_q;

  // Checker state: edges since the last request, saturating.
  logic [QW-1:0] quiet;
  logic          seen;
  always_ff @(posedge clk) begin
    if (srst || req_i) begin
      quiet <= '0;
      seen  <= 1'b1;
    end else if (quiet <= QW'(HOLD)) begin
      quiet <= quiet + 1'b1;
    end
  end

  p_req_asserts_r6: assert property (@(posedge clk) disable iff (srst)
    req_i |=> rst_o);
  p_hold_window_r6: assert property (@(posedge clk) disable iff (srst)
    (seen && quiet <= QW'(HOLD)) |-> rst_o);
  p_release_quiet_r6: assert property (@(posedge clk) disable iff (srst)
    $fell(rst_o) |-> !$past(req_i));
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   srst,
  input  logic   normal_i,
  input  logic   wdog_i,
  input  logic   soft_i,
  input  logic   clr_en_i,
  input  cause_t clr_mask_i,
  output cause_t cause_o
);
  cause_t cause_q;

  always_ff @(posedge clk) begin
    if (srst)          cause_q <= cause_bit(SRC_MASTER);
    else if (normal_i) cause_q <= cause_bit(SRC_NORMAL);
    else if (wdog_i)   cause_q <= cause_bit(SRC_WDOG);
    else if (soft_i)   cause_q <= cause_bit(SRC_SOFT);
    else if (clr_en_i) cause_q <= cause_q & ~clr_mask_i;
  end

  assign cause_o = cause_q;

  p_cause_onehot_r8: assert property (@(posedge clk) disable iff (srst)
    $onehot0(cause_o));
  p_master_cause_r8: assert property (@(posedge clk)
    srst |=> (cause_o == cause_bit(SRC_MASTER)));
  p_normal_first_r9: assert property (@(posedge clk) disable iff (srst)
    normal_i |=> cause_o[SRC_NORMAL]);
  p_wdog_over_soft_r9: assert property (@(posedge clk) disable iff (srst)
    (wdog_i && !normal_i) |=> cause_o[SRC_WDOG]);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               mem_rst_en_n,
  input  logic               wdog_expire,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [CAUSE_W-1:0] reg_wdata,
  output logic               sys_rst_o,
  output logic               mem_rst_o,
  output logic               soft_pending_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic ext_s, men_s;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .d_i(~ext_rst_n), .q_o(ext_s));
  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync_men (
    .clk(clk), .d_i(~mem_rst_en_n), .q_o(men_s));

  // Classification of the synchronized pins
  logic master_s, normal_s;
  assign master_s = ext_s & men_s;
  assign normal_s = ext_s & ~men_s;

  // Software reset request: one firing per write, cleared after release
  logic soft_req, soft_armed, soft_fire, sys_prev, sw_ok, sys_done;
  assign soft_fire = soft_req & ~soft_armed;
  assign sw_ok     = ~sys_rst_o;
  assign sys_done  = sys_prev & ~sys_rst_o;

  always_ff @(posedge clk) begin
    sys_prev <= sys_rst_o;
    if (master_s) begin
      soft_req   <= 1'b0;
      soft_armed <= 1'b0;
    end else begin
      if (soft_armed && sys_done) begin
        soft_req   <= 1'b0;
        soft_armed <= 1'b0;
      end else begin
        if (reg_wr && reg_addr == ADDR_CTRL && sw_ok && reg_wdata[0])
          soft_req <= 1'b1;
        if (soft_fire)
          soft_armed <= 1'b1;
      end
    end
  end

  // Domain requests (master enters both stretchers through srst)
  logic sys_req, mem_req;
  assign sys_req = normal_s | wdog_expire | soft_fire;
  assign mem_req = men_s & (wdog_expire | soft_fire);

  rstc_stretch #(.HOLD(HOLD_CYCLES)) u_str_sys (
    .clk(clk), .srst(master_s), .req_i(sys_req), .rst_o(sys_rst_o));
  rstc_stretch #(.HOLD(HOLD_CYCLES)) u_str_mem (
    .clk(clk), .srst(master_s), .req_i(mem_req), .rst_o(mem_rst_o));

  rstc_cause u_cause (
    .clk       (clk),
    .srst      (master_s),
    .normal_i  (normal_s),
    .wdog_i    (wdog_expire),
    .soft_i    (soft_fire),
    .clr_en_i  (reg_wr && reg_addr == ADDR_CAUSE && sw_ok),
    .clr_mask_i(reg_wdata),
    .cause_o   (cause_o)
  );

  assign soft_pending_o = soft_req;

  p_master_all_r2: assert property (@(posedge clk)
    master_s |=> (sys_rst_o && mem_rst_o));
  p_normal_spares_mem_r3: assert property (@(posedge clk) disable iff (master_s)
    (normal_s && !mem_rst_o) |=> !mem_rst_o);
  p_pin_latency_r1: assert property (@(posedge clk) disable iff (master_s)
    $past(!ext_rst_n, 3) |-> sys_rst_o);
  p_mem_within_sys_r11: assert property (@(posedge clk) disable iff (master_s)
    mem_rst_o |-> sys_rst_o);
  p_wdog_reset_r4: assert property (@(posedge clk) disable iff (master_s)
    wdog_expire |=> sys_rst_o);
  p_soft_clear_r7: assert property (@(posedge clk) disable iff (master_s)
    $fell(soft_pending_o) |-> !sys_rst_o);
  p_write_ignored_r7: assert property (@(posedge clk) disable iff (master_s)
    (sys_rst_o && !soft_pending_o) |=> !soft_pending_o);
endmodule

// File: tb/rstc_top_tb.sv
module rstc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       mem_rst_en_n = 1'b0;
  logic       wdog_expire = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic       sys_rst_o, mem_rst_o, soft_pending_o;
  logic [3:0] cause_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstc_top #(.SYNC_STAGES(2), .HOLD_CYCLES(H)) dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .mem_rst_en_n(mem_rst_en_n),
    .wdog_expire(wdog_expire), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sys_rst_o(sys_rst_o), .mem_rst_o(mem_rst_o),
    .soft_pending_o(soft_pending_o), .cause_o(cause_o));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write(logic a, logic [3:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = 4'h0;
  endtask

  task automatic t_power_on;
    step(10);
    chk("R2 master sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R2 master mem", {7'd0, mem_rst_o}, 8'd1);
    chk("R8 master cause", {4'd0, cause_o}, 8'h1);
    ext_rst_n = 1'b1; mem_rst_en_n = 1'b1;
    step(H + 2);
    chk("R6 master hold sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R6 master hold mem", {7'd0, mem_rst_o}, 8'd1);
    step(1);
    chk("R6 master release sys", {7'd0, sys_rst_o}, 8'd0);
    chk("R6 master release mem", {7'd0, mem_rst_o}, 8'd0);
  endtask

  task automatic t_enable_alone;
    mem_rst_en_n = 1'b0;
    step(6);
    chk("R11 enable alone sys", {7'd0, sys_rst_o}, 8'd0);
    chk("R11 enable alone mem", {7'd0, mem_rst_o}, 8'd0);
    chk("R11 enable alone cause", {4'd0, cause_o}, 8'h1);
    mem_rst_en_n = 1'b1;
    step(3);
  endtask

  task automatic t_normal;
    ext_rst_n = 1'b0;
    step(2);
    chk("R1 not before sync", {7'd0, sys_rst_o}, 8'd0);
    step(1);
    chk("R1/R3 normal sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R3 normal mem spared", {7'd0, mem_rst_o}, 8'd0);
    chk("R8 normal cause", {4'd0, cause_o}, 8'h2);
    step(4);
    ext_rst_n = 1'b1;
    step(H + 2);
    chk("R6 normal hold", {7'd0, sys_rst_o}, 8'd1);
    chk("R3 mem still spared", {7'd0, mem_rst_o}, 8'd0);
    step(1);
    chk("R6 normal release", {7'd0, sys_rst_o}, 8'd0);
  endtask

  task automatic t_wdog_spared;
    wdog_expire = 1'b1;
    step(1);
    wdog_expire = 1'b0;
    chk("R4 wdog sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R4 wdog mem spared", {7'd0, mem_rst_o}, 8'd0);
    chk("R8 wdog cause", {4'd0, cause_o}, 8'h4);
    step(H);
    chk("R6 wdog hold", {7'd0, sys_rst_o}, 8'd1);
    step(1);
    chk("R6 wdog release", {7'd0, sys_rst_o}, 8'd0);
  endtask

  task automatic t_wdog_mem;
    mem_rst_en_n = 1'b0;
    step(3);
    wdog_expire = 1'b1;
    step(1);
    wdog_expire = 1'b0;
    chk("R4 wdog with enable sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R4 wdog with enable mem", {7'd0, mem_rst_o}, 8'd1);
    step(H + 1);
    chk("R6 wdog mem release", {7'd0, mem_rst_o}, 8'd0);
    mem_rst_en_n = 1'b1;
    step(3);
  endtask

  task automatic t_clear;
    write(1'b1, 4'b1011);
    chk("R10 clear other bits keeps", {4'd0, cause_o}, 8'h4);
    write(1'b1, 4'b0100);
    chk("R10 clear hit bit", {4'd0, cause_o}, 8'h0);
  endtask

  task automatic t_soft;
    write(1'b0, 4'b0001);
    chk("R5 soft pending set", {7'd0, soft_pending_o}, 8'd1);
    chk("R5 soft not yet", {7'd0, sys_rst_o}, 8'd0);
    step(1);
    chk("R5 soft sys", {7'd0, sys_rst_o}, 8'd1);
    chk("R5 soft mem spared", {7'd0, mem_rst_o}, 8'd0);
    chk("R8 soft cause", {4'd0, cause_o}, 8'h8);
    write(1'b1, 4'hF);
    chk("R7 clear ignored in reset", {4'd0, cause_o}, 8'h8);
    step(H - 1);
    chk("R6 soft hold", {7'd0, sys_rst_o}, 8'd1);
    step(1);
    chk("R6 soft release", {7'd0, sys_rst_o}, 8'd0);
    chk("R7 pending until after release", {7'd0, soft_pending_o}, 8'd1);
    step(1);
    chk("R7 pending self clear", {7'd0, soft_pending_o}, 8'd0);
    step(5);
    chk("R7 no retrigger", {7'd0, sys_rst_o}, 8'd0);
  endtask

  task automatic t_soft_mem;
    mem_rst_en_n = 1'b0;
    step(3);
    write(1'b0, 4'b0001);
    step(1);
    chk("R5 soft with enable mem", {7'd0, mem_rst_o}, 8'd1);
    step(H + 3);
    chk("R7 soft mem done", {1'b0, mem_rst_o, soft_pending_o, sys_rst_o, cause_o}, 8'h08);
    mem_rst_en_n = 1'b1;
    step(3);
  endtask

  task automatic t_priority;
    write(1'b0, 4'b0001);
    wdog_expire = 1'b1;
    step(1);
    wdog_expire = 1'b0;
    chk("R9 wdog over soft", {4'd0, cause_o}, 8'h4);
    step(H + 3);
    chk("R9 settled", {7'd0, sys_rst_o}, 8'd0);
    ext_rst_n = 1'b0;
    step(2);
    wdog_expire = 1'b1;
    step(1);
    wdog_expire = 1'b0;
    chk("R9 normal over wdog", {4'd0, cause_o}, 8'h2);
    mem_rst_en_n = 1'b0;
    step(3);
    chk("R8 master replaces", {4'd0, cause_o}, 8'h1);
    chk("R2 master mem late enable", {7'd0, mem_rst_o}, 8'd1);
    ext_rst_n = 1'b1; mem_rst_en_n = 1'b1;
    step(H + 4);
    chk("R6 all released", {6'd0, sys_rst_o, mem_rst_o}, 8'd0);
  endtask

  initial begin
    t_power_on();
    t_enable_alone();
    t_normal();
    t_wdog_spared();
    t_wdog_mem();
    t_clear();
    t_soft();
    t_soft_mem();
    t_priority();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule